// File: doc/BRIEF.md
# Three-Segment Gamma Curve Evaluator

This block evaluates one colour channel through a piecewise-linear transfer curve built from three segments of different resolution. An 18-bit input code spans the normalized range 0 to 1 in steps of 1/262144. Near black a superfine segment samples the curve at every code. A fine segment covers the dark region up to 1/128 with a step of 8 codes. A coarse segment covers the remainder with a step of 1024 codes. The segment is chosen from the magnitude of the input code. The block then issues two read addresses to an external, synchronously read LUT for the neighbouring points and interpolates linearly between them on the low code bits.

Table entries are 16 bits wide, so the exact value 1.0 cannot be held in the table. The upper end of the final coarse interval is therefore taken from a per-channel 17-bit maximum value input. The result is rounded and then saturated to 16 bits. Every accepted input produces exactly one result two clock cycles later, flagged by a valid output. Table writes and any other colour stages are outside this block.

Top module: `gamma3seg_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid is 0 and out_code is 0.
- R2: out_valid is high at the second rising edge after each edge that samples in_valid high, and low at the second edge after each edge that samples it low; lut_rd_en equals in_valid.
- R3: For codes below 8 the superfine points are used: point i is stored at LUT address i (0..8), and the result equals the entry at address equal to the code.
- R4: For codes from 8 to 2047, interval k = code >> 3 is used: the lower point is fine point k at address 8 + k, the upper point is at address 9 + k, and the fraction is code[2:0] out of 8.
- R5: For codes of 2048 and above, interval j = code >> 10 is used: the lower point is coarse point j at address 265 + j, the upper point is at address 266 + j, and the fraction is code[9:0] out of 1024.
- R6: For codes of 261120 (interval 255) and above, the upper point is max_value as sampled with the code, not a LUT entry.
- R7: The result is floor((a·N + (b − a)·f + N/2) / N) for lower point a, upper point b, fraction f and step N, i.e. rounding halves upward.
- R8: A result above 65535, possible only when max_value exceeds 65535, is saturated to 65535.
- R9: The block never reads coarse points 0 and 1 (addresses 265 and 266) and never issues an address of 521 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input code is present this cycle |
| in_code | input | 18 | Normalized input code, 0 to 262143 |
| max_value | input | 17 | Curve value at 1.0, sampled with the code |
| lut_rd_en | output | 1 | LUT read request for both addresses |
| lut_addr_lo | output | 10 | LUT address of the lower neighbouring point |
| lut_addr_hi | output | 10 | LUT address of the upper neighbouring point |
| lut_data_lo | input | 16 | Entry at lut_addr_lo, returned one cycle after the request |
| lut_data_hi | input | 16 | Entry at lut_addr_hi, returned one cycle after the request |
| out_valid | output | 1 | Result is present this cycle |
| out_code | output | 16 | Interpolated, rounded and saturated result |

## Verification
The assertions rely on the LUT returning both entries exactly one cycle after a request, with no bubble or reordering. They also require in_valid and in_code to be known on every sampled edge and max_value to stay within 0 to 65536. The bench meets these conditions with a synchronous-read array model that answers every lut_rd_en on the next edge. It drives in_valid on every cycle, including idle ones, and draws max_value only from that range. It changes max_value at negative edges, so each code is paired with one value.

// File: rtl/gamma3seg_pkg.sv
package gamma3seg_pkg;

  // Segment chosen for one input code.
  typedef enum logic [1:0] {
    SEG_SUPER  = 2'd0,
    SEG_FINE   = 2'd1,
    SEG_COARSE = 2'd2
  } seg_e;

  // Default geometry of the curve.
  localparam int unsigned DEF_CODE_W    = 18;
  localparam int unsigned DEF_VAL_W     = 16;
  localparam int unsigned DEF_FINE_SH   = 3;
  localparam int unsigned DEF_COARSE_SH = 10;

endpackage

// File: rtl/gamma3seg_locate.sv
// Segment decode and LUT addressing for one input code (combinational).
module gamma3seg_locate
  import gamma3seg_pkg::*;
#(
  parameter int unsigned CODE_W    = DEF_CODE_W,
  parameter int unsigned FINE_SH   = DEF_FINE_SH,
  parameter int unsigned COARSE_SH = DEF_COARSE_SH,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic [CODE_W-1:0]    code,
  output logic [ADDR_W-1:0]    addr_lo,
  output logic [ADDR_W-1:0]    addr_hi,
  output logic [COARSE_SH-1:0] frac,
  output logic                 use_max
);

  localparam int unsigned SEG_PTS     = 2 ** (CODE_W - COARSE_SH);
  localparam int unsigned SF_PTS      = (2 ** FINE_SH) + 1;
  localparam int unsigned SF_LIMIT    = SF_PTS - 1;
  // The fine segment ends where coarse point 2 begins.
  localparam int unsigned FINE_LIMIT  = SEG_PTS << FINE_SH;
  localparam int unsigned FINE_BASE   = SF_PTS - 1;
  localparam int unsigned COARSE_BASE = SF_PTS + SEG_PTS;
  localparam int unsigned FRAC_GAIN   = COARSE_SH - FINE_SH;

  seg_e seg;

  always_comb begin
    if (code < CODE_W'(SF_LIMIT))        seg = SEG_SUPER;
    else if (code < CODE_W'(FINE_LIMIT)) seg = SEG_FINE;
    else                                 seg = SEG_COARSE;
  end

  always_comb begin
    use_max = 1'b0;
    frac    = '0;
    addr_lo = '0;
    addr_hi = '0;
    case (seg)
      SEG_SUPER: begin
        addr_lo = ADDR_W'(code);
        addr_hi = ADDR_W'(code) + ADDR_W'(1);
      end
      SEG_FINE: begin
        addr_lo = ADDR_W'(FINE_BASE) + ADDR_W'(code >> FINE_SH);
        addr_hi = addr_lo + ADDR_W'(1);
        frac    = COARSE_SH'(code[FINE_SH-1:0]) << FRAC_GAIN;
      end
      default: begin
        addr_lo = ADDR_W'(COARSE_BASE) + ADDR_W'(code >> COARSE_SH);
        frac    = code[COARSE_SH-1:0];
        // Last coarse interval ends at 1.0, held outside the table.
        if (&code[CODE_W-1:COARSE_SH]) begin
          use_max = 1'b1;
          addr_hi = addr_lo;
        end else begin
          addr_hi = addr_lo + ADDR_W'(1);
        end
      end
    endcase
  end

endmodule

// File: rtl/gamma3seg_blend.sv
// Linear interpolation with half-up rounding and 16-bit saturation.
module gamma3seg_blend
  import gamma3seg_pkg::*;
#(
  parameter int unsigned VAL_W  = DEF_VAL_W,
  parameter int unsigned FRAC_W = DEF_COARSE_SH
) (
  input  logic [VAL_W-1:0]  lo_val,
  input  logic [VAL_W:0]    hi_val,
  input  logic [FRAC_W-1:0] frac,
  output logic [VAL_W:0]    raw_val,
  output logic [VAL_W-1:0]  out_val
);

  localparam int unsigned ACC_W = VAL_W + FRAC_W + 4;
  localparam int unsigned HALF  = 2 ** (FRAC_W - 1);

  // a + (b - a) * f / 2^FRAC_W, rounded half up; never negative.
  function automatic logic [VAL_W:0] lerp(
    input logic [VAL_W-1:0]  a,
    input logic [VAL_W:0]    b,
    input logic [FRAC_W-1:0] f
  );
    logic signed [ACC_W-1:0] sa, sb, sf, acc, q;
    sa  = $signed(ACC_W'(a));
    sb  = $signed(ACC_W'(b));
    sf  = $signed(ACC_W'(f));
    acc = (sa <<< FRAC_W) + ((sb - sa) * sf) + $signed(ACC_W'(HALF));
    q   = acc >>> FRAC_W;
    return q[VAL_W:0];
  endfunction

  function automatic logic [VAL_W-1:0] saturate(input logic [VAL_W:0] v);
    return v[VAL_W] ? {VAL_W{1'b1}} : v[VAL_W-1:0];
  endfunction

  always_comb begin
    raw_val = lerp(lo_val, hi_val, frac);
    out_val = saturate(raw_val);
  end

endmodule

// File: rtl/gamma3seg_eval.sv
// Per-channel three-segment gamma evaluator, two-cycle latency.
module gamma3seg_eval
  import gamma3seg_pkg::*;
#(
  parameter int unsigned CODE_W    = DEF_CODE_W,
  parameter int unsigned VAL_W     = DEF_VAL_W,
  parameter int unsigned FINE_SH   = DEF_FINE_SH,
  parameter int unsigned COARSE_SH = DEF_COARSE_SH,
  localparam int unsigned SEG_PTS  = 2 ** (CODE_W - COARSE_SH),
  localparam int unsigned SF_PTS   = (2 ** FINE_SH) + 1,
  localparam int unsigned LUT_DEPTH = SF_PTS + 2 * SEG_PTS,
  localparam int unsigned ADDR_W   = $clog2(LUT_DEPTH),
  localparam int unsigned MAX_W    = VAL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [MAX_W-1:0]  max_value,
  output logic              lut_rd_en,
  output logic [ADDR_W-1:0] lut_addr_lo,
  output logic [ADDR_W-1:0] lut_addr_hi,
  input  logic [VAL_W-1:0]  lut_data_lo,
  input  logic [VAL_W-1:0]  lut_data_hi,
  output logic              out_valid,
  output logic [VAL_W-1:0]  out_code
);

  localparam int unsigned COARSE_BASE = SF_PTS + SEG_PTS;
  localparam int unsigned TOP_START   = (SEG_PTS - 1) << COARSE_SH;

  // Stage 0: decode and address.
  logic [COARSE_SH-1:0] frac_s0;
  logic                 use_max_s0;

  gamma3seg_locate #(
    .CODE_W(CODE_W), .FINE_SH(FINE_SH), .COARSE_SH(COARSE_SH), .ADDR_W(ADDR_W)
  ) u_locate (
    .code    (in_code),
    .addr_lo (lut_addr_lo),
    .addr_hi (lut_addr_hi),
    .frac    (frac_s0),
    .use_max (use_max_s0)
  );

  assign lut_rd_en = in_valid;

  // Stage 1: registers aligned with the LUT read data.
  logic                 valid_s1;
  logic [COARSE_SH-1:0] frac_s1;
  logic                 use_max_s1;
  logic [MAX_W-1:0]     max_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_s1   <= 1'b0;
      frac_s1    <= '0;
      use_max_s1 <= 1'b0;
      max_s1     <= '0;
    end else begin
      valid_s1 <= in_valid;
      if (in_valid) begin
        frac_s1    <= frac_s0;
        use_max_s1 <= use_max_s0;
        max_s1     <= max_value;
      end
    end
  end

  logic [MAX_W-1:0] upper_s1;
  logic [MAX_W-1:0] blend_raw;
  logic [VAL_W-1:0] blend_out;

  assign upper_s1 = use_max_s1 ? max_s1 : {1'b0, lut_data_hi};

  gamma3seg_blend #(.VAL_W(VAL_W), .FRAC_W(COARSE_SH)) u_blend (
    .lo_val  (lut_data_lo),
    .hi_val  (upper_s1),
    .frac    (frac_s1),
    .raw_val (blend_raw),
    .out_val (blend_out)
  );

  // Stage 2: result register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= valid_s1;
      if (valid_s1) out_code <= blend_out;
    end
  end

  // Bounds of the interpolated value: between the two neighbours.
  logic [MAX_W-1:0] bound_lo, bound_hi;
  assign bound_lo = ({1'b0, lut_data_lo} < upper_s1) ? {1'b0, lut_data_lo} : upper_s1;
  assign bound_hi = ({1'b0, lut_data_lo} < upper_s1) ? upper_s1 : {1'b0, lut_data_lo};

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lut_rd_en |-> (lut_addr_lo < ADDR_W'(LUT_DEPTH)) && (lut_addr_hi < ADDR_W'(LUT_DEPTH))
      && (lut_addr_lo != ADDR_W'(COARSE_BASE)) && (lut_addr_lo != ADDR_W'(COARSE_BASE + 1))
      && (lut_addr_hi != ADDR_W'(COARSE_BASE)) && (lut_addr_hi != ADDR_W'(COARSE_BASE + 1)));

  p_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_rd_en && !use_max_s0) |-> (lut_addr_hi == lut_addr_lo + ADDR_W'(1)));

  p_top_interval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lut_rd_en |-> (use_max_s0 == (in_code >= CODE_W'(TOP_START))));

  p_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_s1 |-> (blend_raw >= bound_lo) && (blend_raw <= bound_hi));

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_s1 |=> (out_code == (blend_raw_q[VAL_W] ? {VAL_W{1'b1}} : blend_raw_q[VAL_W-1:0])));

  // Copy of the unsaturated value for the saturation check above.
  logic [MAX_W-1:0] blend_raw_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blend_raw_q <= '0;
    else        blend_raw_q <= blend_raw;
  end

endmodule

// File: tb/gamma3seg_eval_bench.sv
module gamma3seg_eval_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [17:0] in_code;
  logic [16:0] max_value;
  logic        lut_rd_en;
  logic [9:0]  lut_addr_lo, lut_addr_hi;
  logic [15:0] lut_data_lo, lut_data_hi;
  logic        out_valid;
  logic [15:0] out_code;

  always #5 clk = ~clk;

  gamma3seg_eval u_gamma3seg_eval (
    .clk, .rst_n, .in_valid, .in_code, .max_value,
    .lut_rd_en, .lut_addr_lo, .lut_addr_hi, .lut_data_lo, .lut_data_hi,
    .out_valid, .out_code
  );

  logic [15:0] lut_mem [0:520];
  int checks = 0, fails = 0;
  int addr_checks = 0, addr_fails = 0;

  // Synchronous-read LUT model; R9 address checks.
  always @(posedge clk) begin
    if (lut_rd_en) begin
      addr_checks = addr_checks + 1;
      if (lut_addr_lo >= 521 || lut_addr_hi >= 521 || lut_addr_lo == 265 ||
          lut_addr_lo == 266 || lut_addr_hi == 265 || lut_addr_hi == 266) begin
        addr_fails = addr_fails + 1;
        $display("FAIL R9: address lo=%0d hi=%0d, expected below 521 and not 265/266",
                 lut_addr_lo, lut_addr_hi);
      end
      lut_data_lo <= (lut_addr_lo < 521) ? lut_mem[lut_addr_lo] : 16'h0;
      lut_data_hi <= (lut_addr_hi < 521) ? lut_mem[lut_addr_hi] : 16'h0;
    end
  end

  // Expected output, from the requirement text.
  function automatic int expect_of(int code, int mx);
    longint a, b, f, n, r;
    if (code < 8) return int'(lut_mem[code]);                   // R3
    if (code < 2048) begin                                       // R4
      a = lut_mem[8 + (code >> 3)];
      b = lut_mem[9 + (code >> 3)];
      f = code % 8; n = 8;
    end else begin                                               // R5, R6
      a = lut_mem[265 + (code >> 10)];
      b = ((code >> 10) == 255) ? longint'(mx) : longint'(lut_mem[266 + (code >> 10)]);
      f = code % 1024; n = 1024;
    end
    r = (a * n + (b - a) * f + n / 2) / n;                       // R7
    if (r > 65535) r = 65535;                                    // R8
    return int'(r);
  endfunction

  function automatic string tag_of(int code);
    if (code < 8) return "R3";
    if (code < 2048) return "R4";
    if (code >= 261120) return "R6";
    return "R5";
  endfunction

  bit    pv0 = 0, pv1 = 0;
  int    pe0 = 0, pe1 = 0, pc0 = 0, pc1 = 0;
  string pt0 = "", pt1 = "";

  task automatic step(bit v, int code, string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== pv1) begin
      fails++;
      $display("FAIL R2: out_valid=%0b expected %0b", out_valid, pv1);
    end else if (pv1) begin
      checks++;
      if (out_code !== pe1[15:0]) begin
        fails++;
        $display("FAIL %s: code=%0d out_code=%0d expected %0d", pt1, pc1, out_code, pe1);
      end
    end
    pv1 = pv0; pe1 = pe0; pc1 = pc0; pt1 = pt0;
    pv0 = v; pc0 = code; pt0 = tag;
    pe0 = v ? expect_of(code, int'(max_value)) : 0;
    in_valid = v;
    in_code  = 18'(code);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(1'b0, 0, "R2");
  endtask

  bit done = 0;

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + addr_checks + 1, fails + addr_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    for (int i = 0; i < 521; i++) lut_mem[i] = 16'($urandom());
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0; max_value = 17'h10000;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_code !== 16'h0) begin
      fails++;
      $display("FAIL R1: in reset out_valid=%0b out_code=%0d expected 0 0", out_valid, out_code);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_code !== 16'h0) begin
      fails++;
      $display("FAIL R1: after reset out_valid=%0b out_code=%0d expected 0 0", out_valid, out_code);
    end

    // Directed corners: R3..R8.
    lut_mem[520] = 16'hFFF0;
    lut_mem[9]   = 16'd0;
    lut_mem[10]  = 16'd1;
    for (int c = 0; c <= 8; c++) step(1'b1, c, tag_of(c));
    step(1'b1, 11, "R7");
    step(1'b1, 12, "R7");
    step(1'b1, 15, "R4");
    step(1'b1, 2047, "R4");
    step(1'b1, 2048, "R5");
    step(1'b1, 2049, "R5");
    step(1'b1, 261119, "R5");
    step(1'b1, 261120, "R6");
    step(1'b1, 261632, "R6");
    step(1'b1, 262143, "R8");
    drain();

    // Top interval with a smaller maximum: R6.
    max_value = 17'd100;
    step(1'b1, 262000, "R6");
    step(1'b1, 261121, "R6");
    drain();

    // Random phases, max changed between them.
    for (int ph = 0; ph < 3; ph++) begin
      max_value = 17'($urandom_range(0, 65536));
      if (ph == 2) max_value = 17'h10000;
      for (int i = 0; i < 2000; i++) begin
        int c;
        bit v;
        v = ($urandom_range(0, 3) != 0);
        case ($urandom_range(0, 3))
          0: c = $urandom_range(0, 15);
          1: c = $urandom_range(0, 4095);
          2: c = $urandom_range(260000, 262143);
          default: c = $urandom_range(0, 262143);
        endcase
        step(v, c, tag_of(c));
      end
      drain();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + addr_checks, fails + addr_fails);
    $finish;
  end

endmodule